// File: doc/BRIEF.md
# Quadrant-Windowed Queue Flag Status Bus

This block reports per-queue level flags for a bank of 32 queues over two narrow status buses. Each bus is eight bits wide, so it shows one group of eight queues (a quadrant) at a time. The almost-full bus is timed by the write-side clock. The almost-empty bus is timed by the read-side clock. Each bus also outputs the index of the quadrant it is currently showing, so a monitor knows which queues the eight bits describe.

Both buses share one selection mode. In polled mode, each bus moves to the next quadrant on every clock edge and wraps around after the last one. It always visits all four quadrants, however many queues are configured. In direct mode, each side picks its quadrant through its own address and load strobe, and the two sides do not affect each other. Bits for queues beyond the configured queue count are driven to the inactive (low) level. The flag vectors themselves come from elsewhere.

Top module: `qstat_window_pair`

## Requirements
- R1: While a side's active-low reset is sampled low at its clock edge, that side's quadrant output becomes 0 and its bus becomes all zero.
- R2: In polled mode (`poll_mode` = 1), each clock edge advances the side's quadrant index by one in the order 0, 1, 2, 3, 0, ...
- R3: After each edge, bus bit i equals the flag of queue 8*q+i, where q is the newly registered quadrant and the flag vector is the one sampled at that same edge. Queue n is flag bit n.
- R4: Bus bits for a queue whose number is not below `queue_count` read 0. Polled mode still steps through all four quadrants when fewer than 32 queues are configured.
- R5: In direct mode (`poll_mode` = 0), an edge with the side's load strobe high takes the side's 2-bit address as the new quadrant. An edge without the strobe keeps the quadrant unchanged.
- R6: In polled mode, the load strobes and addresses have no effect on either side's quadrant sequence.
- R7: The write-side address and strobe only steer the almost-full bus. The read-side address and strobe only steer the almost-empty bus.
- R8: The single `poll_mode` input selects the mode for both buses at once. An edge where direct mode and a load strobe arrive together applies that load.
- R9: A `queue_count` of 0 makes every bus bit 0. Any count of 32 or more treats all 32 queues as configured.
- R10: In direct mode with the quadrant held, the bus is refreshed from the current flag vector on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Clock for the almost-full side |
| wr_rst_n | input | 1 | Synchronous active-low reset, almost-full side |
| rd_clk | input | 1 | Clock for the almost-empty side |
| rd_rst_n | input | 1 | Synchronous active-low reset, almost-empty side |
| poll_mode | input | 1 | 1 = polled stepping, 0 = direct addressing (both sides) |
| queue_count | input | 6 | Number of configured queues (0..32, larger saturates) |
| af_flags | input | 32 | Almost-full flag per queue, bit n = queue n |
| ae_flags | input | 32 | Almost-empty flag per queue, bit n = queue n |
| wr_quad_addr | input | 2 | Quadrant requested for the almost-full bus |
| wr_quad_load | input | 1 | Strobe that loads `wr_quad_addr` in direct mode |
| rd_quad_addr | input | 2 | Quadrant requested for the almost-empty bus |
| rd_quad_load | input | 1 | Strobe that loads `rd_quad_addr` in direct mode |
| af_bus | output | 8 | Almost-full flags of the shown quadrant |
| af_quad | output | 2 | Quadrant shown on `af_bus` |
| ae_bus | output | 8 | Almost-empty flags of the shown quadrant |
| ae_quad | output | 2 | Quadrant shown on `ae_bus` |

## Verification
Two pairs of functions can land on the same edge.

The first pair is quadrant stepping and load strobing. The bench raises both strobes, with addresses that differ from the next polled quadrant, while polled mode is active. It passes only if the sequence continues unchanged.

The second pair is a mode switch and a load. The bench drops `poll_mode` on the very edge that carries a load on each side, with different addresses. It expects each bus to jump to its own address at once. Partial queue counts are run through full polled sweeps, so masking and stepping are judged together.

// File: rtl/qstat_pkg.sv
// Shared definitions for the quadrant flag status window.
// Assumes nothing beyond the encoding of the selection mode.
package qstat_pkg;

    // Selection mode of the status buses; value matches the poll_mode pin.
    typedef enum logic {
        SEL_DIRECT = 1'b0,
        SEL_POLLED = 1'b1
    } sel_mode_e;

    // Number of index bits needed to address n items (at least one bit).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/qstat_quad_sel.sv
// Quadrant selection register for one status bus.
// Polled mode steps cyclically through all quadrants.
// Direct mode loads the requested quadrant on a strobe and otherwise holds.
// Assumes the address is synchronous to clk.
// Out-of-range addresses (possible only when NQUAD is not a power of two) are ignored.
module qstat_quad_sel
    import qstat_pkg::*;
#(
    parameter int NQUAD = 4,
    parameter int QW    = idx_bits(NQUAD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          poll_mode,
    input  logic [QW-1:0] quad_addr,
    input  logic          quad_load,
    output logic [QW-1:0] q_next,
    output logic [QW-1:0] q_cur
);

    localparam logic [QW-1:0] Q_LAST = QW'(NQUAD - 1);

    sel_mode_e mode;

    assign mode = sel_mode_e'(poll_mode);

    // Next quadrant: cyclic step when polled, strobe-driven load when direct.
    always_comb begin
        q_next = q_cur;
        if (mode == SEL_POLLED) begin
            q_next = (q_cur == Q_LAST) ? '0 : QW'(q_cur + 1'b1);
        end else if (quad_load && (quad_addr <= Q_LAST)) begin
            q_next = quad_addr;
        end
    end

    // Quadrant register with synchronous active-low reset to quadrant 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cur <= '0;
        end else begin
            q_cur <= q_next;
        end
    end

endmodule

// File: rtl/qstat_cfg_mask.sv
// Configured-queue mask: bit n is set when queue n is below the configured count.
// Counts at or above NUM_QUEUES mark every queue as configured.
// Purely combinational.
module qstat_cfg_mask #(
    parameter int NUM_QUEUES = 32,
    parameter int CNT_W      = $clog2(NUM_QUEUES + 1)
) (
    input  logic [CNT_W-1:0]      queue_count,
    output logic [NUM_QUEUES-1:0] cfg_mask
);

    // One comparator per queue position.
    for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_cmp
        assign cfg_mask[g] = (queue_count > CNT_W'(g));
    end

endmodule

// File: rtl/qstat_slice_mux.sv
// Cuts the flag vector into quadrants and substitutes the idle level on
// unconfigured positions. Returns the quadrant chosen by sel.
// Purely combinational.
// Assumes NUM_QUEUES is a multiple of GROUP_W.
module qstat_slice_mux #(
    parameter int   NUM_QUEUES = 32,
    parameter int   GROUP_W    = 8,
    parameter int   NQUAD      = NUM_QUEUES / GROUP_W,
    parameter int   QW         = 2,
    parameter logic FLAG_IDLE  = 1'b0
) (
    input  logic [NUM_QUEUES-1:0] flags,
    input  logic [NUM_QUEUES-1:0] cfg_mask,
    input  logic [QW-1:0]         sel,
    output logic [GROUP_W-1:0]    slice
);

    logic [GROUP_W-1:0] groups [NQUAD];

    // Per-quadrant masked group: live flag where configured, idle level elsewhere.
    for (genvar k = 0; k < NQUAD; k++) begin : g_grp
        assign groups[k] = (flags[k*GROUP_W +: GROUP_W] & cfg_mask[k*GROUP_W +: GROUP_W])
                         | (~cfg_mask[k*GROUP_W +: GROUP_W] & {GROUP_W{FLAG_IDLE}});
    end

    // Quadrant selection.
    always_comb begin
        slice = {GROUP_W{FLAG_IDLE}};
        for (int k = 0; k < NQUAD; k++) begin
            if (sel == QW'(k)) begin
                slice = groups[k];
            end
        end
    end

endmodule

// File: rtl/qstat_flagbus.sv
// One quadrant-windowed status bus.
// Selects a quadrant, masks unconfigured queues and registers the bus
// together with the quadrant index, so both change on the same edge.
// Assumes every input is synchronous to clk.
module qstat_flagbus
    import qstat_pkg::*;
#(
    parameter int   NUM_QUEUES = 32,
    parameter int   GROUP_W    = 8,
    parameter logic FLAG_IDLE  = 1'b0,
    parameter int   NQUAD      = NUM_QUEUES / GROUP_W,
    parameter int   QW         = idx_bits(NQUAD),
    parameter int   CNT_W      = $clog2(NUM_QUEUES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  poll_mode,
    input  logic [QW-1:0]         quad_addr,
    input  logic                  quad_load,
    input  logic [NUM_QUEUES-1:0] flags,
    input  logic [CNT_W-1:0]      queue_count,
    output logic [GROUP_W-1:0]    bus,
    output logic [QW-1:0]         quad
);

    logic [QW-1:0]         q_next;
    logic [NUM_QUEUES-1:0] cfg_mask;
    logic [GROUP_W-1:0]    slice;

    qstat_quad_sel #(
        .NQUAD (NQUAD),
        .QW    (QW)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll_mode (poll_mode),
        .quad_addr (quad_addr),
        .quad_load (quad_load),
        .q_next    (q_next),
        .q_cur     (quad)
    );

    qstat_cfg_mask #(
        .NUM_QUEUES (NUM_QUEUES),
        .CNT_W      (CNT_W)
    ) u_mask (
        .queue_count (queue_count),
        .cfg_mask    (cfg_mask)
    );

    qstat_slice_mux #(
        .NUM_QUEUES (NUM_QUEUES),
        .GROUP_W    (GROUP_W),
        .NQUAD      (NQUAD),
        .QW         (QW),
        .FLAG_IDLE  (FLAG_IDLE)
    ) u_mux (
        .flags    (flags),
        .cfg_mask (cfg_mask),
        .sel      (q_next),
        .slice    (slice)
    );

    // Bus register, loaded from the quadrant that the index register takes on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus <= {GROUP_W{FLAG_IDLE}};
        end else begin
            bus <= slice;
        end
    end

endmodule

// File: rtl/qstat_window_pair.sv
// Top level: an almost-full status bus on the write clock and an
// almost-empty status bus on the read clock.
// They share the selection mode and the configured queue count.
// Assumes poll_mode and queue_count are static or synchronous to both clocks.
module qstat_window_pair
    import qstat_pkg::*;
#(
    parameter int   NUM_QUEUES = 32,
    parameter int   GROUP_W    = 8,
    parameter logic FLAG_IDLE  = 1'b0,
    parameter int   NQUAD      = NUM_QUEUES / GROUP_W,
    parameter int   QW         = idx_bits(NQUAD),
    parameter int   CNT_W      = $clog2(NUM_QUEUES + 1)
) (
    input  logic                  wr_clk,
    input  logic                  wr_rst_n,
    input  logic                  rd_clk,
    input  logic                  rd_rst_n,
    input  logic                  poll_mode,
    input  logic [CNT_W-1:0]      queue_count,
    input  logic [NUM_QUEUES-1:0] af_flags,
    input  logic [NUM_QUEUES-1:0] ae_flags,
    input  logic [QW-1:0]         wr_quad_addr,
    input  logic                  wr_quad_load,
    input  logic [QW-1:0]         rd_quad_addr,
    input  logic                  rd_quad_load,
    output logic [GROUP_W-1:0]    af_bus,
    output logic [QW-1:0]         af_quad,
    output logic [GROUP_W-1:0]    ae_bus,
    output logic [QW-1:0]         ae_quad
);

    // Almost-full window, write clock domain.
    qstat_flagbus #(
        .NUM_QUEUES (NUM_QUEUES),
        .GROUP_W    (GROUP_W),
        .FLAG_IDLE  (FLAG_IDLE),
        .NQUAD      (NQUAD),
        .QW         (QW),
        .CNT_W      (CNT_W)
    ) u_af (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .poll_mode   (poll_mode),
        .quad_addr   (wr_quad_addr),
        .quad_load   (wr_quad_load),
        .flags       (af_flags),
        .queue_count (queue_count),
        .bus         (af_bus),
        .quad        (af_quad)
    );

    // Almost-empty window, read clock domain.
    qstat_flagbus #(
        .NUM_QUEUES (NUM_QUEUES),
        .GROUP_W    (GROUP_W),
        .FLAG_IDLE  (FLAG_IDLE),
        .NQUAD      (NQUAD),
        .QW         (QW),
        .CNT_W      (CNT_W)
    ) u_ae (
        .clk         (rd_clk),
        .rst_n       (rd_rst_n),
        .poll_mode   (poll_mode),
        .quad_addr   (rd_quad_addr),
        .quad_load   (rd_quad_load),
        .flags       (ae_flags),
        .queue_count (queue_count),
        .bus         (ae_bus),
        .quad        (ae_quad)
    );

endmodule

// File: rtl/qstat_flagbus_chk.sv
// Property checker for one status bus, bound twice into the top level.
// Relates the bus and quadrant outputs to the inputs over time.
module qstat_flagbus_chk #(
    parameter int   NUM_QUEUES = 32,
    parameter int   GROUP_W    = 8,
    parameter logic FLAG_IDLE  = 1'b0,
    parameter int   NQUAD      = NUM_QUEUES / GROUP_W,
    parameter int   QW         = 2,
    parameter int   CNT_W      = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  poll_mode,
    input logic [QW-1:0]         quad_addr,
    input logic                  quad_load,
    input logic [NUM_QUEUES-1:0] flags,
    input logic [CNT_W-1:0]      queue_count,
    input logic [GROUP_W-1:0]    bus,
    input logic [QW-1:0]         quad
);

    localparam logic [QW-1:0] Q_LAST = QW'(NQUAD - 1);

    function automatic logic [GROUP_W-1:0] group_of(input logic [NUM_QUEUES-1:0] f,
                                                   input logic [QW-1:0] q);
        logic [GROUP_W-1:0] r;
        r = '0;
        for (int k = 0; k < NQUAD; k++) begin
            if (q == QW'(k)) r = f[k*GROUP_W +: GROUP_W];
        end
        return r;
    endfunction

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (quad == '0 && bus == {GROUP_W{FLAG_IDLE}}));

    p_poll_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        poll_mode |=> quad == (($past(quad) == Q_LAST) ? '0 : QW'($past(quad) + 1'b1)));

    p_full_slice_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_count >= CNT_W'(NUM_QUEUES)) |=> bus == group_of($past(flags), quad));

    p_direct_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_mode && quad_load) |=> quad == $past(quad_addr));

    p_direct_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_mode && !quad_load) |=> $stable(quad));

    p_no_config_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_count == '0) |=> bus == {GROUP_W{FLAG_IDLE}});

endmodule

bind qstat_window_pair qstat_flagbus_chk #(
    .NUM_QUEUES (NUM_QUEUES),
    .GROUP_W    (GROUP_W),
    .FLAG_IDLE  (FLAG_IDLE),
    .NQUAD      (NQUAD),
    .QW         (QW),
    .CNT_W      (CNT_W)
) u_chk_af (
    .clk         (wr_clk),
    .rst_n       (wr_rst_n),
    .poll_mode   (poll_mode),
    .quad_addr   (wr_quad_addr),
    .quad_load   (wr_quad_load),
    .flags       (af_flags),
    .queue_count (queue_count),
    .bus         (af_bus),
    .quad        (af_quad)
);

bind qstat_window_pair qstat_flagbus_chk #(
    .NUM_QUEUES (NUM_QUEUES),
    .GROUP_W    (GROUP_W),
    .FLAG_IDLE  (FLAG_IDLE),
    .NQUAD      (NQUAD),
    .QW         (QW),
    .CNT_W      (CNT_W)
) u_chk_ae (
    .clk         (rd_clk),
    .rst_n       (rd_rst_n),
    .poll_mode   (poll_mode),
    .quad_addr   (rd_quad_addr),
    .quad_load   (rd_quad_load),
    .flags       (ae_flags),
    .queue_count (queue_count),
    .bus         (ae_bus),
    .quad        (ae_quad)
);

// File: tb/qstat_window_pair_test.sv
// Directed bench: one task per scenario, each checking the outputs after every edge.
module qstat_window_pair_test;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst_n  = 1'b0;
    logic        poll_mode = 1'b1;
    logic [5:0]  queue_count = 6'd32;
    logic [31:0] af_flags = '0;
    logic [31:0] ae_flags = '0;
    logic [1:0]  wr_quad_addr = '0;
    logic        wr_quad_load = 1'b0;
    logic [1:0]  rd_quad_addr = '0;
    logic        rd_quad_load = 1'b0;
    logic [7:0]  af_bus, ae_bus;
    logic [1:0]  af_quad, ae_quad;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_af_q = '0;
    logic [1:0] exp_ae_q = '0;
    logic [7:0] exp_af_bus = '0;
    logic [7:0] exp_ae_bus = '0;

    qstat_window_pair uut (
        .wr_clk       (wr_clk),
        .wr_rst_n     (rst_n),
        .rd_clk       (rd_clk),
        .rd_rst_n     (rst_n),
        .poll_mode    (poll_mode),
        .queue_count  (queue_count),
        .af_flags     (af_flags),
        .ae_flags     (ae_flags),
        .wr_quad_addr (wr_quad_addr),
        .wr_quad_load (wr_quad_load),
        .rd_quad_addr (rd_quad_addr),
        .rd_quad_load (rd_quad_load),
        .af_bus       (af_bus),
        .af_quad      (af_quad),
        .ae_bus       (ae_bus),
        .ae_quad      (ae_quad)
    );

    // 200 MHz on both sides; the read clock lags by 1 ns.
    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #1;
        forever #2.5 rd_clk = ~rd_clk;
    end

    function automatic logic [7:0] exp_bus(input logic [31:0] f, input logic [1:0] q,
                                           input logic [5:0] cnt);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            int n;
            n = 8 * q + i;
            r[i] = (n < cnt) ? f[n] : 1'b0;
        end
        return r;
    endfunction

    function automatic logic [31:0] pat(input int s);
        return 32'hA5C3_0F96 ^ (32'(s) * 32'h9E37_79B9);
    endfunction

    task automatic cmp(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One edge on each clock: predict from the driven inputs, wait, compare.
    task automatic tick(input string tag);
        if (!rst_n) begin
            exp_af_q = '0;
            exp_ae_q = '0;
            exp_af_bus = '0;
            exp_ae_bus = '0;
        end else begin
            if (poll_mode) begin
                exp_af_q = exp_af_q + 2'd1;
                exp_ae_q = exp_ae_q + 2'd1;
            end else begin
                if (wr_quad_load) exp_af_q = wr_quad_addr;
                if (rd_quad_load) exp_ae_q = rd_quad_addr;
            end
            exp_af_bus = exp_bus(af_flags, exp_af_q, queue_count);
            exp_ae_bus = exp_bus(ae_flags, exp_ae_q, queue_count);
        end
        @(posedge wr_clk);
        #2.5;
        cmp(tag, "af_quad", {6'd0, af_quad}, {6'd0, exp_af_q});
        cmp(tag, "ae_quad", {6'd0, ae_quad}, {6'd0, exp_ae_q});
        cmp(tag, "af_bus", af_bus, exp_af_bus);
        cmp(tag, "ae_bus", ae_bus, exp_ae_bus);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        af_flags = '1;
        ae_flags = '1;
        tick("R1");
        tick("R1");
        rst_n = 1'b1;
    endtask

    task automatic t_poll_full();
        poll_mode = 1'b1;
        queue_count = 6'd32;
        for (int s = 0; s < 6; s++) begin
            af_flags = pat(s);
            ae_flags = ~pat(s + 11);
            tick("R2 R3");
        end
    endtask

    task automatic t_partial_mask();
        poll_mode = 1'b1;
        af_flags = '1;
        ae_flags = '1;
        queue_count = 6'd22;
        for (int s = 0; s < 4; s++) tick("R4");
        queue_count = 6'd1;
        for (int s = 0; s < 4; s++) tick("R4");
        queue_count = 6'd0;
        for (int s = 0; s < 4; s++) tick("R9");
        queue_count = 6'd40;
        for (int s = 0; s < 4; s++) begin
            af_flags = pat(s + 20);
            ae_flags = pat(s + 30);
            tick("R9");
        end
    endtask

    task automatic t_direct();
        poll_mode = 1'b0;
        queue_count = 6'd32;
        wr_quad_addr = 2'd2;
        wr_quad_load = 1'b1;
        rd_quad_addr = 2'd1;
        rd_quad_load = 1'b1;
        tick("R5 R7");
        wr_quad_load = 1'b0;
        rd_quad_load = 1'b0;
        wr_quad_addr = 2'd0;
        rd_quad_addr = 2'd3;
        for (int s = 0; s < 3; s++) begin
            af_flags = pat(s + 40);
            ae_flags = pat(s + 50);
            tick("R5 R10");
        end
        wr_quad_addr = 2'd3;
        wr_quad_load = 1'b1;
        tick("R7");
        wr_quad_load = 1'b0;
        rd_quad_addr = 2'd0;
        rd_quad_load = 1'b1;
        tick("R7");
        rd_quad_load = 1'b0;
    endtask

    task automatic t_poll_ignores_load();
        poll_mode = 1'b1;
        wr_quad_load = 1'b1;
        rd_quad_load = 1'b1;
        for (int s = 0; s < 4; s++) begin
            wr_quad_addr = 2'(s + 2);
            rd_quad_addr = 2'(s);
            af_flags = pat(s + 60);
            ae_flags = pat(s + 70);
            tick("R6");
        end
        wr_quad_load = 1'b0;
        rd_quad_load = 1'b0;
    endtask

    task automatic t_shared_mode();
        // Mode switch and load strobes on the same edge.
        poll_mode = 1'b0;
        wr_quad_addr = 2'd1;
        rd_quad_addr = 2'd3;
        wr_quad_load = 1'b1;
        rd_quad_load = 1'b1;
        tick("R8");
        wr_quad_load = 1'b0;
        rd_quad_load = 1'b0;
        tick("R8");
        poll_mode = 1'b1;
        for (int s = 0; s < 3; s++) tick("R8");
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_poll_full();
        t_partial_mask();
        t_direct();
        t_poll_ignores_load();
        t_shared_mode();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule